// File: doc/BRIEF.md
# Namespace Prefix Scope Resolver

This block tracks XML namespace bindings for a markup front end and answers which URI a prefix names at the current point in the document. The front end has already turned prefix strings and URI strings into small integer IDs. It sends one command per cycle. A command can declare that a prefix ID is bound to a URI ID, open a new element scope, close the innermost scope, or ask for the URI currently bound to a prefix.

Each distinct (prefix, URI) pair gets a binding number, and a table keeps the pair for that number. Every prefix keeps a history bit vector that marks all binding numbers it has ever used. A single visible vector marks the bindings in scope. A resolve ANDs the prefix history with the visible vector and scans the result for a set bit. The URI comes from the table for that bit.

While a scope is open, the block accumulates the visible bits that its declarations flipped. Opening a deeper scope pushes that accumulated change vector onto a stack. Closing a scope XORs the change vector back into the visible vector in one cycle, however many declarations the scope made. Misuse raises a sticky error flag: a new pair when the table is full, an open when the stack is full, or a close at the outermost scope.

Top module: `ns_scope_resolver`

## Requirements
- R1: After reset the error flag is 0, the response outputs are 0, and a resolve of any prefix returns found 0 with URI 0.
- R2: A resolve issued in cycle n drives rspValid high in cycle n+1 with the result, where the result reflects every command accepted before cycle n. rspValid is low in any cycle that does not follow a resolve.
- R3: A resolve of a prefix with no visible binding returns found 0 and URI 0.
- R4: A declaration made inside an inner scope hides the enclosing binding of the same prefix, so only one binding per prefix is visible at a time.
- R5: Closing a scope brings back exactly the bindings that were visible before that scope was opened, at every nesting depth.
- R6: Declaring a (prefix, URI) pair that already has a binding number reuses that number and allocates no new one. This holds even when the table of 32 bindings is full.
- R7: Declaring a new pair when all 32 binding numbers are in use sets the error flag and leaves every resolve result unchanged.
- R8: A close command at the outermost scope sets the error flag and changes no binding.
- R9: The stack holds 32 open scopes. An open command beyond that depth sets the error flag and is ignored, so the next close still undoes the 32nd scope.
- R10: The error flag stays at 1 until reset, while the other commands keep working.
- R11: Repeated declarations of one prefix within one scope leave the latest visible, and a single close undoes all of them.
- R12: A declaration of one prefix leaves the result of every other prefix unchanged.
- R13: Command encoding on cmdOp: 0 declare, 1 open, 2 close, 3 resolve. cmdPrefix and cmdUri are used only by declare and resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 2 | Command code (see R13) |
| cmdPrefix | input | 4 | Prefix ID for declare or resolve |
| cmdUri | input | 8 | URI ID for declare |
| rspValid | output | 1 | Resolve result is valid this cycle |
| rspFound | output | 1 | A visible binding exists for the prefix |
| rspUri | output | 8 | URI ID of the visible binding, 0 if none |
| errFlag | output | 1 | Sticky misuse flag |

## Verification
The assertions assume that the front end sends at most one command per cycle and that its fields carry known values whenever cmdValid is high. The one-visible-binding-per-prefix and visible-subset-of-allocated checks also assume that nothing but the command port changes the binding state. The stimulus drives every field to a defined value on each cycle, including idle cycles. It fills the binding table and the scope stack exactly to their limits and one step past them. It applies a reset between phases so that the sticky flag from one misuse does not hide the next. A seeded random run over a few prefixes and URIs then mixes all four commands against a reference model that saves and restores the whole prefix map per scope.

// File: rtl/ns_scope_pkg.sv
package ns_scope_pkg;

  typedef enum logic [1:0] {
    OP_DECLARE = 2'd0,
    OP_OPEN    = 2'd1,
    OP_CLOSE   = 2'd2,
    OP_RESOLVE = 2'd3
  } nsOp_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic doDeclare;
    logic doOpen;
    logic doClose;
    logic doResolve;
  } nsStrobe_t;

endpackage

// File: rtl/ns_scope_ctrl.sv
module ns_scope_ctrl
  import ns_scope_pkg::*;
#(
  parameter int STACK_DEPTH = 32,
  localparam int DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic          declFail,
  output nsStrobe_t     strobes,
  output logic [DW-1:0] depthPtr,
  output logic          errFlag
);

  localparam logic [DW-1:0] DEPTH_MAX = DW'(STACK_DEPTH);

  logic isOpen, isClose, stackFull, stackEmpty;
  logic openReject, closeReject;

  assign isOpen      = cmdValid && (cmdOp == OP_OPEN);
  assign isClose     = cmdValid && (cmdOp == OP_CLOSE);
  assign stackFull   = (depthPtr == DEPTH_MAX);
  assign stackEmpty  = (depthPtr == '0);
  assign openReject  = isOpen && stackFull;
  assign closeReject = isClose && stackEmpty;

  always_comb begin
    strobes           = '0;
    strobes.doDeclare = cmdValid && (cmdOp == OP_DECLARE);
    strobes.doResolve = cmdValid && (cmdOp == OP_RESOLVE);
    strobes.doOpen    = isOpen && !stackFull;
    strobes.doClose   = isClose && !stackEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthPtr <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (strobes.doOpen)       depthPtr <= depthPtr + DW'(1);
      else if (strobes.doClose) depthPtr <= depthPtr - DW'(1);
      if (openReject || closeReject || declFail) errFlag <= 1'b1;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8
  close_empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    closeReject |=> (depthPtr == '0) && errFlag);

  // R9
  open_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    openReject |=> (depthPtr == DEPTH_MAX) && errFlag);

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthPtr <= DEPTH_MAX);

endmodule

// File: rtl/ns_scope_datapath.sv
module ns_scope_datapath
  import ns_scope_pkg::*;
#(
  parameter int NUM_BIND    = 32,
  parameter int NUM_PFX     = 16,
  parameter int URI_W       = 8,
  parameter int STACK_DEPTH = 32,
  localparam int PFX_W = $clog2(NUM_PFX),
  localparam int BID_W = $clog2(NUM_BIND),
  localparam int CNT_W = $clog2(NUM_BIND + 1),
  localparam int DW    = $clog2(STACK_DEPTH + 1),
  localparam int SP_W  = $clog2(STACK_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  nsStrobe_t        strobes,
  input  logic [DW-1:0]    depthPtr,
  input  logic [PFX_W-1:0] cmdPrefix,
  input  logic [URI_W-1:0] cmdUri,
  output logic             declFail,
  output logic             rspValid,
  output logic             rspFound,
  output logic [URI_W-1:0] rspUri
);

  typedef logic [NUM_BIND-1:0] bindVec_t;

  // binding table, entries valid below allocCnt
  logic [PFX_W-1:0] tabPfx [NUM_BIND];
  logic [URI_W-1:0] tabUri [NUM_BIND];
  logic [CNT_W-1:0] allocCnt;

  bindVec_t history [NUM_PFX];
  bindVec_t visible;
  bindVec_t curDelta;
  bindVec_t deltaStack [STACK_DEPTH];

  // associative lookup of the declared pair
  bindVec_t         hitVec;
  logic             pairHit, tableFull, declOk;
  logic [BID_W-1:0] hitIdx, newId;
  bindVec_t         newBit, newVis, changedBits;

  for (genvar i = 0; i < NUM_BIND; i++) begin : g_cam
    assign hitVec[i] = (CNT_W'(i) < allocCnt) &&
                       (tabPfx[i] == cmdPrefix) && (tabUri[i] == cmdUri);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_BIND; i++) begin
      if (hitVec[i]) hitIdx = BID_W'(i);
    end
  end

  assign pairHit     = |hitVec;
  assign tableFull   = (allocCnt == CNT_W'(NUM_BIND));
  assign declFail    = strobes.doDeclare && !pairHit && tableFull;
  assign declOk      = strobes.doDeclare && !declFail;
  assign newId       = pairHit ? hitIdx : allocCnt[BID_W-1:0];
  assign newBit      = bindVec_t'(1) << newId;
  assign newVis      = (visible & ~history[cmdPrefix]) | newBit;
  assign changedBits = visible ^ newVis;

  // resolve: history AND visible, then scan for the set bit
  bindVec_t         matchVec;
  logic [BID_W-1:0] matchIdx;
  logic             matchAny;

  assign matchVec = history[cmdPrefix] & visible;
  assign matchAny = |matchVec;

  always_comb begin
    matchIdx = '0;
    for (int i = NUM_BIND - 1; i >= 0; i--) begin
      if (matchVec[i]) matchIdx = BID_W'(i);
    end
  end

  // scope stack slot below the current depth
  logic [DW-1:0] belowPtr;
  assign belowPtr = depthPtr - DW'(1);

  always_ff @(posedge clk) begin
    if (declOk && !pairHit) begin
      tabPfx[allocCnt[BID_W-1:0]] <= cmdPrefix;
      tabUri[allocCnt[BID_W-1:0]] <= cmdUri;
    end
    if (strobes.doOpen) deltaStack[depthPtr[SP_W-1:0]] <= curDelta;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocCnt <= '0;
      visible  <= '0;
      curDelta <= '0;
      rspValid <= 1'b0;
      rspFound <= 1'b0;
      rspUri   <= '0;
      for (int p = 0; p < NUM_PFX; p++) history[p] <= '0;
    end else begin
      rspValid <= strobes.doResolve;
      rspFound <= strobes.doResolve && matchAny;
      rspUri   <= (strobes.doResolve && matchAny) ? tabUri[matchIdx] : '0;
      if (declOk) begin
        if (!pairHit) allocCnt <= allocCnt + CNT_W'(1);
        history[cmdPrefix] <= history[cmdPrefix] | newBit;
        visible  <= newVis;
        curDelta <= curDelta ^ changedBits;
      end else if (strobes.doOpen) begin
        curDelta <= '0;
      end else if (strobes.doClose) begin
        visible  <= visible ^ curDelta;
        curDelta <= deltaStack[belowPtr[SP_W-1:0]];
      end
    end
  end

  for (genvar p = 0; p < NUM_PFX; p++) begin : g_pfx_chk
    // R4
    one_visible_per_pfx_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones(history[p] & visible) <= 1);
  end

  // R6
  visible_allocated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (visible >> allocCnt) == '0);

  // R7
  full_decl_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    declFail |=> $stable(visible) && $stable(allocCnt));

  // R3
  not_found_zero_uri_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspFound |-> (rspUri == '0));

  // R6
  alloc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocCnt <= CNT_W'(NUM_BIND));

endmodule

// File: rtl/ns_scope_resolver.sv
module ns_scope_resolver
  import ns_scope_pkg::*;
#(
  parameter int NUM_BIND    = 32,
  parameter int NUM_PFX     = 16,
  parameter int URI_W       = 8,
  parameter int STACK_DEPTH = 32,
  localparam int PFX_W = $clog2(NUM_PFX),
  localparam int DW    = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [PFX_W-1:0] cmdPrefix,
  input  logic [URI_W-1:0] cmdUri,
  output logic             rspValid,
  output logic             rspFound,
  output logic [URI_W-1:0] rspUri,
  output logic             errFlag
);

  nsStrobe_t     strobes;
  logic [DW-1:0] depthPtr;
  logic          declFail;

  ns_scope_ctrl #(.STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .declFail (declFail),
    .strobes  (strobes),
    .depthPtr (depthPtr),
    .errFlag  (errFlag)
  );

  ns_scope_datapath #(
    .NUM_BIND    (NUM_BIND),
    .NUM_PFX     (NUM_PFX),
    .URI_W       (URI_W),
    .STACK_DEPTH (STACK_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .depthPtr  (depthPtr),
    .cmdPrefix (cmdPrefix),
    .cmdUri    (cmdUri),
    .declFail  (declFail),
    .rspValid  (rspValid),
    .rspFound  (rspFound),
    .rspUri    (rspUri)
  );

  // R2
  resolve_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_RESOLVE) |=> rspValid);

  // R2
  no_spurious_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdOp == OP_RESOLVE) |=> !rspValid);

endmodule

// File: tb/ns_scope_resolver_bench.sv
`timescale 1ns/1ps
module ns_scope_resolver_bench;

  localparam int NB = 32;
  localparam int NP = 16;
  localparam int SD = 32;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdValid;
  logic [1:0] cmdOp;
  logic [3:0] cmdPrefix;
  logic [7:0] cmdUri;
  logic       rspValid, rspFound, errFlag;
  logic [7:0] rspUri;

  always #2 clk = ~clk;

  ns_scope_resolver u_ns_scope_resolver (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPrefix(cmdPrefix), .cmdUri(cmdUri), .rspValid(rspValid),
    .rspFound(rspFound), .rspUri(rspUri), .errFlag(errFlag)
  );

  // reference model: prefix map, saved maps per open scope, pair list
  int mapUri [NP];
  int saved [$];
  int bPfx [$];
  int bUri [$];
  bit mErr, eValid, eFound;
  int eUri;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic modelReset();
    for (int k = 0; k < NP; k++) mapUri[k] = -1;
    saved.delete(); bPfx.delete(); bUri.delete();
    mErr = 0; eValid = 0; eFound = 0; eUri = 0;
  endtask

  task automatic compare(string req);
    checks++;
    if (rspValid !== eValid || rspFound !== eFound ||
        rspUri !== 8'(eUri) || errFlag !== mErr) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b uri=%0d err=%0b exp v=%0b f=%0b uri=%0d err=%0b",
               req, rspValid, rspFound, rspUri, errFlag, eValid, eFound, eUri, mErr);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; cmdValid = 0; cmdOp = 0; cmdPrefix = 0; cmdUri = 0;
    @(posedge clk); @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  // drive one command (or idle when v=0), update model, compare after the edge
  task automatic step(bit v, int op, int p, int u, string req);
    bit hit;
    cmdValid = v; cmdOp = 2'(op); cmdPrefix = 4'(p); cmdUri = 8'(u);
    eValid = 0; eFound = 0; eUri = 0;
    if (v) begin
      case (op)
        0: begin
          hit = 0;
          foreach (bPfx[i]) if (bPfx[i] == p && bUri[i] == u) hit = 1;
          if (hit || bPfx.size() < NB) begin
            if (!hit) begin bPfx.push_back(p); bUri.push_back(u); end
            mapUri[p] = u;
          end else mErr = 1;
        end
        1: if (saved.size() / NP == SD) mErr = 1;
           else for (int k = 0; k < NP; k++) saved.push_back(mapUri[k]);
        2: if (saved.size() == 0) mErr = 1;
           else for (int k = NP - 1; k >= 0; k--) mapUri[k] = saved.pop_back();
        default: begin
          eValid = 1;
          if (mapUri[p] >= 0) begin eFound = 1; eUri = mapUri[p]; end
        end
      endcase
    end
    @(posedge clk); @(negedge clk);
    compare(req);
  endtask

  task automatic res(int p, string req);
    step(1, 3, p, 0, req);
  endtask

  initial begin
    rstN = 0; cmdValid = 0; cmdOp = 0; cmdPrefix = 0; cmdUri = 0;
    modelReset();
    doReset();
    // R1 reset state and empty resolve
    step(0, 0, 0, 0, "R1");
    res(3, "R1");
    res(0, "R1");

    // R2 R3 R4 R11 R12 R5: nested scopes
    step(1, 0, 1, 10, "R2");
    res(1, "R2");
    step(0, 0, 0, 0, "R2");
    res(2, "R3");
    step(1, 1, 0, 0, "R13");
    step(1, 0, 1, 20, "R4");
    step(1, 0, 2, 30, "R12");
    res(1, "R4");
    res(2, "R12");
    step(1, 0, 1, 21, "R11");
    res(1, "R11");
    step(1, 1, 0, 0, "R5");
    step(1, 0, 1, 40, "R4");
    step(1, 0, 3, 50, "R12");
    step(1, 0, 1, 41, "R11");
    res(1, "R11");
    res(3, "R12");
    step(1, 2, 0, 0, "R5");
    res(1, "R5");
    res(3, "R5");
    step(1, 2, 0, 0, "R5");
    res(1, "R5");
    res(2, "R5");
    step(1, 0, 1, 20, "R6");
    res(1, "R6");

    // R9 deep nesting to the stack limit
    doReset();
    for (int i = 0; i < SD; i++) begin
      step(1, 1, 0, 0, "R9");
      step(1, 0, i % NP, 100 + i, "R9");
    end
    res(5, "R9");
    step(1, 1, 0, 0, "R9");
    step(1, 2, 0, 0, "R9");
    res(15, "R9");
    for (int i = 0; i < SD - 1; i++) begin
      step(1, 2, 0, 0, "R5");
      res(i % NP, "R5");
    end
    step(1, 2, 0, 0, "R10");
    res(0, "R10");

    // R8 close at outermost scope
    doReset();
    step(1, 0, 7, 77, "R8");
    step(1, 2, 0, 0, "R8");
    res(7, "R8");
    step(1, 0, 7, 78, "R10");
    res(7, "R10");

    // R6 R7 full table
    doReset();
    for (int i = 0; i < NB; i++) step(1, 0, i % NP, 200 + i, "R6");
    res(0, "R6");
    step(1, 0, 0, 200, "R6");
    res(0, "R6");
    step(1, 0, 5, 99, "R7");
    res(5, "R7");
    res(0, "R7");

    // mixed seeded traffic against the model
    doReset();
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 9);
      int op = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : 3;
      if (i % 500 == 0) doReset();
      step($urandom_range(0, 7) != 0, op, $urandom_range(0, 3),
           $urandom_range(0, 7), "R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule